// File: doc/BRIEF.md
# PCI Configuration Access Engine

The engine sits between a CPU register port and an abstract PCI transaction port and turns a software request into one configuration cycle. Software writes a target word (bus, device slot, function, register offset), optionally a write-data word, and then a control word carrying access size, direction and whether the access goes to the bridge's own configuration space. That control write starts the transaction.

From these fields the engine builds the configuration address word. It picks the single-bit device select form on bus 0 and the routed form on other buses. It builds an active-low byte-enable nibble and places it in a command word. It moves write data onto the correct byte lanes. It also pulls the requested bytes out of the returned 32-bit read word. Errors reported by the PCI side during the address phase are latched with their faulting address in write-one-to-clear status fields. While any such error is pending, a remote access never reaches its data phase.

The PCI side has two phases, each held until acknowledged: an address/command phase and a data phase. Only one transaction is in flight at a time.

Top module: `pci_cfg_engine`

## Requirements
- R1: On bus 0 the address word is `(1 << slot) | (function << 8) | (offset & 0xFC)`, so bit 0 is 0.
- R2: On a nonzero bus the address word is `bus << 16 | slot << 11 | function << 8 | (offset & 0xFC) | 1`.
- R3: A remote command word has the opcode in bits [3:0] (0xA read, 0xB write) and active-low byte enables in bits [7:4]. A 4-byte access gives 0000. A 1-byte access clears only lane (offset mod 4). A 2-byte access clears lanes (offset mod 4) and the lane above it.
- R4: A local access (control bit 4) drives address word 0 and command `be << 20 | 1 << 16 | (offset & 0xFC)`. It always proceeds to its data phase, even when errors are reported.
- R5: Write data on `pci_wdata` equals the WDATA register shifted left by 8×(offset mod 4).
- R6: RDATA (index 3) holds the returned word shifted right by 8×(offset mod 4), masked to 8, 16 or 32 bits by the size.
- R7: STATUS (index 4) bits [1:0] latch `pci_err_bus` and bit 2 latches `pci_err_host` at the address acknowledge. BUS_EADDR (index 5) and HOST_EADDR (index 6) hold `pci_err_addr` for each. Writing a 1 to a status bit clears it; writing a 0 leaves it unchanged.
- R8: If any error bit is set after the address acknowledge of a remote access, no data phase follows. This includes a bit left uncleared from an earlier access. A read then yields all-ones masked to its size; a write is dropped.
- R9: The request is rejected: no PCI phase starts and STATUS bit 3 is set (write-one-to-clear). This happens when the size (control bits [2:0]) is not 1, 2 or 4, when the access crosses a dword boundary (2 bytes at offset mod 4 = 3, or 4 bytes at a nonzero offset mod 4), or when a local access is a read (control bit 3 = 0).
- R10: STATUS bit 8 shows a transaction in flight. A control write during that time is ignored and never issued later. The address and data phases are never active together.
- R11: After reset every CPU-readable register reads 0 and neither PCI phase is active.
- R12: `pci_req` with its address and command, and `pci_dat` with its data, stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 3 | CPU register index (0 TARGET, 1 CONTROL, 2 WDATA, 3 RDATA, 4 STATUS, 5 BUS_EADDR, 6 HOST_EADDR) |
| cpu_wdata | input | 32 | CPU write data; TARGET layout offset [7:0], function [10:8], slot [15:11], bus [23:16] |
| cpu_rdata | output | 32 | CPU read data of the indexed register |
| pci_req | output | 1 | Address/command phase active |
| pci_local | output | 1 | Transaction targets the bridge's own configuration space |
| pci_addr | output | 32 | Configuration address word |
| pci_cmd | output | 32 | Command word with byte enables |
| pci_req_ack | input | 1 | Address phase accepted; error inputs valid |
| pci_err_bus | input | 2 | PCI bus error code for this address phase |
| pci_err_host | input | 1 | Host bus error for this address phase |
| pci_err_addr | input | 32 | Faulting address reported with an error |
| pci_dat | output | 1 | Data phase active |
| pci_write | output | 1 | Data phase direction, 1 for write |
| pci_wdata | output | 32 | Lane-aligned write data |
| pci_dat_ack | input | 1 | Data phase complete; read data valid |
| pci_rdata | input | 32 | Returned 32-bit read word |

## Verification
The bench drives configuration accesses at offsets inside the dword and on both bus kinds. A swapped address form, a shifted or inverted byte-enable nibble, or a wrong lane shift shows up as a wrong address, command, write word or extracted read byte. Error tests check that an error code blocks the data phase, both on its own access and as a leftover from an earlier one, and that a masked all-ones value is returned; a design that cleared errors on read or ignored uncleared ones would start a data phase. Reject cases (size 3, a crossing 2-byte access, a local read) must start no PCI phase. A control write issued while busy must neither change the live address nor start a second transaction afterwards.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DW        = 32;
    localparam int BUS_W     = 8;
    localparam int SLOT_W    = 5;
    localparam int FUNC_W    = 3;
    localparam int OFS_W     = 8;
    localparam int LANES     = DW / 8;
    localparam int LANE_W    = $clog2(LANES);
    localparam int SIZE_W    = 3;
    localparam int EBUS_W    = 2;

    // CPU register indices
    localparam int RI_TARGET = 0;
    localparam int RI_CTRL   = 1;
    localparam int RI_WDATA  = 2;
    localparam int RI_RDATA  = 3;
    localparam int RI_STATUS = 4;
    localparam int RI_BEADDR = 5;
    localparam int RI_HEADDR = 6;

    // status bit positions
    localparam int ST_HOST   = 2;
    localparam int ST_REJ    = 3;
    localparam int ST_BUSY   = 8;

    // command word layout
    localparam logic [3:0] OP_CFG_RD = 4'hA;
    localparam logic [3:0] OP_CFG_WR = 4'hB;
    localparam int REM_BE_LSB = 4;
    localparam int LCL_BE_LSB = 20;
    localparam int LCL_WR_BIT = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [DW-1:0]     addr;
        logic [DW-1:0]     cmd;
        logic [DW-1:0]     wdata;
        logic              write;
        logic              is_local;
        logic [LANE_W-1:0] lane;
        logic [SIZE_W-1:0] size;
    } txn_desc_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] size,
                                        input logic [LANE_W-1:0] lane);
        logic ok;
        case (size)
            3'd1:    ok = 1'b1;
            3'd2:    ok = (lane != 2'd3);
            3'd4:    ok = (lane == 2'd0);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [LANES-1:0] lane_enables_n(input logic [SIZE_W-1:0] size,
                                                        input logic [LANE_W-1:0] lane);
        logic [LANES-1:0] be;
        case (size)
            3'd1:    be = ~(4'b0001 << lane);
            3'd2:    be = ~(4'b0011 << lane);
            default: be = 4'b0000;
        endcase
        return be;
    endfunction

    function automatic logic [DW-1:0] cfg_address(input logic [BUS_W-1:0]  bus,
                                                  input logic [SLOT_W-1:0] slot,
                                                  input logic [FUNC_W-1:0] func,
                                                  input logic [OFS_W-1:0]  ofs);
        logic [DW-1:0] a;
        if (bus == '0) begin
            a = (32'd1 << slot)
              | {21'd0, func, 8'd0}
              | {24'd0, ofs[OFS_W-1:2], 2'b00};
        end else begin
            a = {8'd0, bus, slot, func, ofs[OFS_W-1:2], 2'b01};
        end
        return a;
    endfunction

    function automatic logic [DW-1:0] lane_align(input logic [DW-1:0] d,
                                                 input logic [LANE_W-1:0] lane);
        return d << {lane, 3'b000};
    endfunction

    function automatic logic [DW-1:0] lane_extract(input logic [DW-1:0] raw,
                                                   input logic [LANE_W-1:0] lane,
                                                   input logic [SIZE_W-1:0] size);
        logic [DW-1:0] s;
        logic [DW-1:0] r;
        s = raw >> {lane, 3'b000};
        case (size)
            3'd1:    r = {24'd0, s[7:0]};
            3'd2:    r = {16'd0, s[15:0]};
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
    import cfg_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [SIZE_W-1:0] size,
    input  logic              write,
    input  logic              is_local,
    input  logic [DW-1:0]     wdata,
    output txn_desc_t         desc,
    output logic              reject
);
    logic [LANE_W-1:0] lane;
    logic [LANES-1:0]  be_n;

    assign lane = ofs[LANE_W-1:0];
    assign be_n = lane_enables_n(size, lane);

    always_comb begin
        reject = !size_legal(size, lane) || (is_local && !write);

        desc          = '0;
        desc.write    = write;
        desc.is_local = is_local;
        desc.lane     = lane;
        desc.size     = size;
        desc.wdata    = lane_align(wdata, lane);

        if (is_local) begin
            desc.addr = '0;
            desc.cmd[LCL_BE_LSB +: LANES] = be_n;
            desc.cmd[LCL_WR_BIT]          = 1'b1;
            desc.cmd[OFS_W-1:0]           = {ofs[OFS_W-1:2], 2'b00};
        end else begin
            desc.addr = cfg_address(bus, slot, func, ofs);
            desc.cmd[REM_BE_LSB +: LANES] = be_n;
            desc.cmd[3:0]                 = write ? OP_CFG_WR : OP_CFG_RD;
        end
    end

endmodule

// File: rtl/cfg_err_status.sv
module cfg_err_status
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [EBUS_W-1:0] err_bus,
    input  logic              err_host,
    input  logic [DW-1:0]     err_addr,
    input  logic              reject_set,
    input  logic              clr_we,
    input  logic [DW-1:0]     clr_mask,
    output logic [EBUS_W-1:0] bus_err_q,
    output logic              host_err_q,
    output logic              reject_q,
    output logic [DW-1:0]     bus_eaddr_q,
    output logic [DW-1:0]     host_eaddr_q,
    output logic              pending
);
    logic [EBUS_W-1:0] bus_in;
    logic              host_in;
    logic [EBUS_W-1:0] bus_clr;
    logic              host_clr;
    logic              rej_clr;

    assign bus_in   = capture ? err_bus : '0;
    assign host_in  = capture & err_host;
    assign bus_clr  = clr_we ? clr_mask[EBUS_W-1:0] : '0;
    assign host_clr = clr_we & clr_mask[ST_HOST];
    assign rej_clr  = clr_we & clr_mask[ST_REJ];

    // error state as seen after this cycle's capture
    assign pending = ((bus_err_q | bus_in) != '0) || host_err_q || host_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_err_q    <= '0;
            host_err_q   <= 1'b0;
            reject_q     <= 1'b0;
            bus_eaddr_q  <= '0;
            host_eaddr_q <= '0;
        end else begin
            bus_err_q  <= (bus_err_q & ~bus_clr) | bus_in;
            host_err_q <= (host_err_q & ~host_clr) | host_in;
            reject_q   <= (reject_q & ~rej_clr) | reject_set;
            if (bus_in != '0) bus_eaddr_q  <= err_addr;
            if (host_in)      host_eaddr_q <= err_addr;
        end
    end

endmodule

// File: rtl/cfg_txn_seq.sv
module cfg_txn_seq
    import cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ok,
    input  txn_desc_t     desc_in,
    input  logic          pending,
    input  logic          req_ack,
    input  logic          dat_ack,
    input  logic [DW-1:0] rdata_in,
    output txn_desc_t     desc_q,
    output logic          busy,
    output logic          req_on,
    output logic          dat_on,
    output logic          capture,
    output logic [DW-1:0] result_q
);
    seq_state_e state_q;

    assign req_on  = (state_q == SEQ_ADDR);
    assign dat_on  = (state_q == SEQ_DATA);
    assign busy    = (state_q != SEQ_IDLE);
    assign capture = req_on & req_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            desc_q   <= '0;
            result_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        desc_q  <= desc_in;
                        state_q <= SEQ_ADDR;
                    end
                end
                SEQ_ADDR: begin
                    if (req_ack) begin
                        if (!desc_q.is_local && pending) begin
                            if (!desc_q.write)
                                result_q <= lane_extract('1, desc_q.lane, desc_q.size);
                            state_q <= SEQ_IDLE;
                        end else begin
                            state_q <= SEQ_DATA;
                        end
                    end
                end
                SEQ_DATA: begin
                    if (dat_ack) begin
                        if (!desc_q.write)
                            result_q <= lane_extract(rdata_in, desc_q.lane, desc_q.size);
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pci_cfg_engine.sv
module pci_cfg_engine
    import cfg_pkg::*;
#(
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [RIDX_W-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              pci_req,
    output logic              pci_local,
    output logic [DW-1:0]     pci_addr,
    output logic [DW-1:0]     pci_cmd,
    input  logic              pci_req_ack,
    input  logic [EBUS_W-1:0] pci_err_bus,
    input  logic              pci_err_host,
    input  logic [DW-1:0]     pci_err_addr,
    output logic              pci_dat,
    output logic              pci_write,
    output logic [DW-1:0]     pci_wdata,
    input  logic              pci_dat_ack,
    input  logic [DW-1:0]     pci_rdata
);
    localparam int TGT_W = OFS_W + FUNC_W + SLOT_W + BUS_W;

    logic [BUS_W-1:0]  tgt_bus;
    logic [SLOT_W-1:0] tgt_slot;
    logic [FUNC_W-1:0] tgt_func;
    logic [OFS_W-1:0]  tgt_ofs;
    logic [SIZE_W-1:0] ctl_size;
    logic              ctl_write;
    logic              ctl_local;
    logic [DW-1:0]     wdata_q;

    logic we_tgt, we_ctl, we_wd, we_st;
    logic busy, go, go_ok, go_rej;

    txn_desc_t desc_new, desc_q;
    logic      dec_reject;
    logic      capture, pending;
    logic [DW-1:0] result_q;

    logic [EBUS_W-1:0] bus_err_q;
    logic              host_err_q, reject_q;
    logic [DW-1:0]     bus_eaddr_q, host_eaddr_q;

    assign we_tgt = cpu_we && (cpu_addr == RIDX_W'(RI_TARGET));
    assign we_ctl = cpu_we && (cpu_addr == RIDX_W'(RI_CTRL));
    assign we_wd  = cpu_we && (cpu_addr == RIDX_W'(RI_WDATA));
    assign we_st  = cpu_we && (cpu_addr == RIDX_W'(RI_STATUS));

    assign go     = we_ctl && !busy;
    assign go_ok  = go && !dec_reject;
    assign go_rej = go && dec_reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_bus   <= '0;
            tgt_slot  <= '0;
            tgt_func  <= '0;
            tgt_ofs   <= '0;
            ctl_size  <= '0;
            ctl_write <= 1'b0;
            ctl_local <= 1'b0;
            wdata_q   <= '0;
        end else begin
            if (we_tgt) begin
                {tgt_bus, tgt_slot, tgt_func, tgt_ofs} <= cpu_wdata[TGT_W-1:0];
            end
            if (go) begin
                ctl_size  <= cpu_wdata[SIZE_W-1:0];
                ctl_write <= cpu_wdata[SIZE_W];
                ctl_local <= cpu_wdata[SIZE_W+1];
            end
            if (we_wd) wdata_q <= cpu_wdata;
        end
    end

    // decode uses the control word being written, so the start edge launches it
    cfg_req_decode u_dec (
        .bus      (tgt_bus),
        .slot     (tgt_slot),
        .func     (tgt_func),
        .ofs      (tgt_ofs),
        .size     (cpu_wdata[SIZE_W-1:0]),
        .write    (cpu_wdata[SIZE_W]),
        .is_local (cpu_wdata[SIZE_W+1]),
        .wdata    (wdata_q),
        .desc     (desc_new),
        .reject   (dec_reject)
    );

    cfg_txn_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_ok (go_ok),
        .desc_in  (desc_new),
        .pending  (pending),
        .req_ack  (pci_req_ack),
        .dat_ack  (pci_dat_ack),
        .rdata_in (pci_rdata),
        .desc_q   (desc_q),
        .busy     (busy),
        .req_on   (pci_req),
        .dat_on   (pci_dat),
        .capture  (capture),
        .result_q (result_q)
    );

    cfg_err_status u_st (
        .clk          (clk),
        .rst          (rst),
        .capture      (capture),
        .err_bus      (pci_err_bus),
        .err_host     (pci_err_host),
        .err_addr     (pci_err_addr),
        .reject_set   (go_rej),
        .clr_we       (we_st),
        .clr_mask     (cpu_wdata),
        .bus_err_q    (bus_err_q),
        .host_err_q   (host_err_q),
        .reject_q     (reject_q),
        .bus_eaddr_q  (bus_eaddr_q),
        .host_eaddr_q (host_eaddr_q),
        .pending      (pending)
    );

    assign pci_local = desc_q.is_local;
    assign pci_addr  = desc_q.addr;
    assign pci_cmd   = desc_q.cmd;
    assign pci_write = desc_q.write;
    assign pci_wdata = desc_q.wdata;

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            RIDX_W'(RI_TARGET): cpu_rdata[TGT_W-1:0] = {tgt_bus, tgt_slot, tgt_func, tgt_ofs};
            RIDX_W'(RI_CTRL):   cpu_rdata[SIZE_W+1:0] = {ctl_local, ctl_write, ctl_size};
            RIDX_W'(RI_WDATA):  cpu_rdata = wdata_q;
            RIDX_W'(RI_RDATA):  cpu_rdata = result_q;
            RIDX_W'(RI_STATUS): begin
                cpu_rdata[EBUS_W-1:0] = bus_err_q;
                cpu_rdata[ST_HOST]    = host_err_q;
                cpu_rdata[ST_REJ]     = reject_q;
                cpu_rdata[ST_BUSY]    = busy;
            end
            RIDX_W'(RI_BEADDR): cpu_rdata = bus_eaddr_q;
            RIDX_W'(RI_HEADDR): cpu_rdata = host_eaddr_q;
            default:            cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_engine_checker.sv
module cfg_engine_checker (
    input logic        clk,
    input logic        rst,
    input logic        pci_req,
    input logic        pci_req_ack,
    input logic        pci_dat,
    input logic        pci_dat_ack,
    input logic        pci_local,
    input logic        pci_write,
    input logic [31:0] pci_addr,
    input logic [31:0] pci_cmd,
    input logic [31:0] pci_wdata,
    input logic [1:0]  pci_err_bus,
    input logic        pci_err_host
);

    assert_one_phase_R10: assert property (@(posedge clk) disable iff (rst)
        !(pci_req && pci_dat));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        pci_req && !pci_req_ack |=> pci_req && $stable(pci_addr) && $stable(pci_cmd));

    assert_dat_hold_R12: assert property (@(posedge clk) disable iff (rst)
        pci_dat && !pci_dat_ack |=> pci_dat && $stable(pci_wdata) && $stable(pci_write));

    assert_err_blocks_data_R8: assert property (@(posedge clk) disable iff (rst)
        pci_req && pci_req_ack && !pci_local && ((pci_err_bus != 2'b00) || pci_err_host)
        |=> !pci_dat);

    assert_be_shape_R3: assert property (@(posedge clk) disable iff (rst)
        pci_req && !pci_local |-> ($countones(pci_cmd[7:4]) != 1) && ($countones(pci_cmd[7:4]) != 4));

    assert_local_is_write_R4: assert property (@(posedge clk) disable iff (rst)
        pci_dat && pci_local |-> pci_write);

    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pci_req && !pci_dat);

endmodule

bind pci_cfg_engine cfg_engine_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .pci_req      (pci_req),
    .pci_req_ack  (pci_req_ack),
    .pci_dat      (pci_dat),
    .pci_dat_ack  (pci_dat_ack),
    .pci_local    (pci_local),
    .pci_write    (pci_write),
    .pci_addr     (pci_addr),
    .pci_cmd      (pci_cmd),
    .pci_wdata    (pci_wdata),
    .pci_err_bus  (pci_err_bus),
    .pci_err_host (pci_err_host)
);

// File: tb/tb_pci_cfg_engine.sv
`timescale 1ns/1ps
module tb_pci_cfg_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        pci_req, pci_local, pci_dat, pci_write;
    logic [31:0] pci_addr, pci_cmd, pci_wdata;
    logic        pci_req_ack = 1'b0;
    logic [1:0]  pci_err_bus = '0;
    logic        pci_err_host = 1'b0;
    logic [31:0] pci_err_addr = '0;
    logic        pci_dat_ack = 1'b0;
    logic [31:0] pci_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pci_cfg_engine dut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pci_req(pci_req), .pci_local(pci_local), .pci_addr(pci_addr),
        .pci_cmd(pci_cmd), .pci_req_ack(pci_req_ack), .pci_err_bus(pci_err_bus),
        .pci_err_host(pci_err_host), .pci_err_addr(pci_err_addr),
        .pci_dat(pci_dat), .pci_write(pci_write), .pci_wdata(pci_wdata),
        .pci_dat_ack(pci_dat_ack), .pci_rdata(pci_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic target(input logic [7:0] bus, input logic [4:0] slot,
                          input logic [2:0] func, input logic [7:0] ofs);
        wr(3'd0, {8'd0, bus, slot, func, ofs});
    endtask

    task automatic go(input logic [2:0] size, input logic write, input logic lcl);
        wr(3'd1, {27'd0, lcl, write, size});
    endtask

    task automatic addr_ack(input logic [1:0] eb, input logic eh, input logic [31:0] ea);
        pci_req_ack = 1'b1; pci_err_bus = eb; pci_err_host = eh; pci_err_addr = ea;
        @(negedge clk);
        pci_req_ack = 1'b0; pci_err_bus = '0; pci_err_host = 1'b0; pci_err_addr = '0;
    endtask

    task automatic dat_ack(input logic [31:0] rdv);
        pci_dat_ack = 1'b1; pci_rdata = rdv;
        @(negedge clk);
        pci_dat_ack = 1'b0; pci_rdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R11 register after reset", v, 32'h0);
        end
        chk("R11 pci_req after reset", {31'd0, pci_req}, 32'h0);
        chk("R11 pci_dat after reset", {31'd0, pci_dat}, 32'h0);
    endtask

    task automatic t_type0_read;
        logic [31:0] v;
        target(8'd0, 5'd17, 3'd0, 8'h04);
        go(3'd4, 1'b0, 1'b0);
        chk("R1 type0 address", pci_addr, 32'h0002_0004);
        chk("R3 read dword command", pci_cmd, 32'h0000_000A);
        repeat (3) @(negedge clk);
        chk("R12 request held", {31'd0, pci_req}, 32'h1);
        chk("R12 address held", pci_addr, 32'h0002_0004);
        addr_ack(2'b00, 1'b0, 32'h0);
        chk("R6 data phase opens", {31'd0, pci_dat}, 32'h1);
        chk("R6 read direction", {31'd0, pci_write}, 32'h0);
        dat_ack(32'hDEAD_BEEF);
        rd(3'd3, v);
        chk("R6 dword read data", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_type1_byte;
        logic [31:0] v;
        target(8'd2, 5'd3, 3'd1, 8'h12);
        go(3'd1, 1'b0, 1'b0);
        chk("R2 type1 address", pci_addr, 32'h0002_1911);
        chk("R3 byte enable lane2", pci_cmd, 32'h0000_00BA);
        addr_ack(2'b00, 1'b0, 32'h0);
        dat_ack(32'h1122_3344);
        rd(3'd3, v);
        chk("R6 byte extract lane2", v, 32'h0000_0022);
    endtask

    task automatic t_word_write;
        wr(3'd2, 32'h1234_ABCD);
        target(8'd0, 5'd20, 3'd2, 8'h41);
        go(3'd2, 1'b1, 1'b0);
        chk("R1 type0 address with function", pci_addr, 32'h0010_0240);
        chk("R3 word enables lanes1-2", pci_cmd, 32'h0000_009B);
        addr_ack(2'b00, 1'b0, 32'h0);
        chk("R5 write data phase", {31'd0, pci_dat}, 32'h1);
        chk("R5 write direction", {31'd0, pci_write}, 32'h1);
        chk("R5 lane aligned data", pci_wdata, 32'h34AB_CD00);
        dat_ack(32'h0);
    endtask

    task automatic t_local;
        logic [31:0] v;
        wr(3'd2, 32'h0000_0356);
        target(8'd0, 5'd0, 3'd0, 8'h04);
        go(3'd4, 1'b1, 1'b1);
        chk("R4 local flag", {31'd0, pci_local}, 32'h1);
        chk("R4 local address zero", pci_addr, 32'h0);
        chk("R4 local dword command", pci_cmd, 32'h0001_0004);
        addr_ack(2'b00, 1'b0, 32'h0);
        chk("R4 local dword data", pci_wdata, 32'h0000_0356);
        dat_ack(32'h0);
        wr(3'd2, 32'h0000_005A);
        target(8'd0, 5'd0, 3'd0, 8'h06);
        go(3'd1, 1'b1, 1'b1);
        chk("R4 local byte command", pci_cmd, 32'h00B1_0004);
        addr_ack(2'b01, 1'b0, 32'h0000_1000);
        chk("R4 local proceeds despite error", {31'd0, pci_dat}, 32'h1);
        chk("R5 local byte lane data", pci_wdata, 32'h005A_0000);
        dat_ack(32'h0);
        rd(3'd4, v);
        chk("R7 bus error latched on local", v, 32'h1);
        wr(3'd4, 32'h1);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        target(8'd0, 5'd18, 3'd0, 8'h02);
        go(3'd2, 1'b0, 1'b0);
        chk("R3 word enables lanes2-3", pci_cmd, 32'h0000_003A);
        addr_ack(2'b10, 1'b0, 32'hCAFE_0000);
        chk("R8 no data phase after bus error", {31'd0, pci_dat}, 32'h0);
        rd(3'd3, v);
        chk("R8 masked all-ones word", v, 32'h0000_FFFF);
        rd(3'd4, v);
        chk("R7 bus error code", v, 32'h2);
        rd(3'd5, v);
        chk("R7 bus error address", v, 32'hCAFE_0000);
        wr(3'd2, 32'h77);
        go(3'd1, 1'b1, 1'b0);
        addr_ack(2'b00, 1'b0, 32'h0);
        chk("R8 sticky error drops write", {31'd0, pci_dat}, 32'h0);
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        chk("R7 writing zero bit keeps error", v, 32'h2);
        wr(3'd4, 32'h2);
        rd(3'd4, v);
        chk("R7 write-one clears", v, 32'h0);
        target(8'd0, 5'd17, 3'd0, 8'h08);
        go(3'd4, 1'b0, 1'b0);
        addr_ack(2'b00, 1'b1, 32'h0BAD_0000);
        chk("R8 no data phase after host error", {31'd0, pci_dat}, 32'h0);
        rd(3'd3, v);
        chk("R8 all-ones dword", v, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R7 host error bit", v, 32'h4);
        rd(3'd6, v);
        chk("R7 host error address", v, 32'h0BAD_0000);
        wr(3'd4, 32'h4);
        rd(3'd4, v);
        chk("R7 host error cleared", v, 32'h0);
    endtask

    task automatic t_reject;
        logic [31:0] v;
        target(8'd0, 5'd17, 3'd0, 8'h00);
        go(3'd3, 1'b0, 1'b0);
        chk("R9 size 3 no request", {31'd0, pci_req}, 32'h0);
        rd(3'd4, v);
        chk("R9 size 3 flagged", v, 32'h8);
        wr(3'd4, 32'h8);
        target(8'd0, 5'd17, 3'd0, 8'h03);
        go(3'd2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 crossing word no request", {31'd0, pci_req}, 32'h0);
        rd(3'd4, v);
        chk("R9 crossing word flagged", v, 32'h8);
        wr(3'd4, 32'h8);
        target(8'd0, 5'd0, 3'd0, 8'h04);
        go(3'd4, 1'b0, 1'b1);
        chk("R9 local read no request", {31'd0, pci_req}, 32'h0);
        rd(3'd4, v);
        chk("R9 local read flagged", v, 32'h8);
        wr(3'd4, 32'h8);
        rd(3'd4, v);
        chk("R9 reject flag cleared", v, 32'h0);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        target(8'd0, 5'd17, 3'd0, 8'h00);
        go(3'd4, 1'b0, 1'b0);
        target(8'd5, 5'd9, 3'd0, 8'h00);
        go(3'd4, 1'b0, 1'b0);
        chk("R10 in-flight address kept", pci_addr, 32'h0002_0000);
        rd(3'd4, v);
        chk("R10 busy flag", v, 32'h100);
        addr_ack(2'b00, 1'b0, 32'h0);
        dat_ack(32'h0000_5555);
        @(negedge clk);
        chk("R10 ignored start not issued", {31'd0, pci_req}, 32'h0);
        rd(3'd4, v);
        chk("R10 idle after completion", v, 32'h0);
        rd(3'd3, v);
        chk("R6 busy test read data", v, 32'h0000_5555);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_type0_read();
        t_type1_byte();
        t_word_write();
        t_local();
        t_errors();
        t_reject();
        t_busy();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule